// File: doc/BRIEF.md
# Adaptive Hysteresis Band Current Comparator

One phase of a hysteresis current controller whose band is re-tuned once per switching period, so that the switching period follows a programmed target. Every clock it takes a signed current-error sample for its own phase and the component of the error that all three phases share. It removes the shared part and compares the remaining non-interacting error against a symmetric band. The switch output goes high above the upper threshold and low below the lower one. One full high-then-low excursion counts as one switching period.

The block measures the spacing, in clock cycles, between successive rising edges of the switch output. After each finished period it starts a multi-cycle update. This update multiplies the present band by the target period and then divides by the measured period on a sequential divider. The result is a first-order dead-beat correction and needs no plant parameters. The result is clamped to a programmable window. It replaces the band only once the division has finished, so the old band stays in use until then.

The parameters `CLK_HZ` and `SW_HZ` (default 50 MHz and 5 kHz) size the period counter to cover four times the nominal target count. The target itself is driven as a cycle count on `target_cycles`.

Top module: `adaptive_hyst_cmp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sw_out` is 0, `period_meas` is 0 and `band_out` equals `band_init`.
- R2: With d = `err_in` − `shared_in` (signed), the edge after a sample with d > `band_out` leaves `sw_out` = 1, and the edge after a sample with d < −`band_out` leaves `sw_out` = 0. A sample with d equal to +`band_out` or −`band_out`, or between them, leaves `sw_out` unchanged.
- R3: The comparison depends only on the difference d. Adding the same offset to `err_in` and `shared_in` does not change the switching decision.
- R4: At each rising edge of `sw_out` after the first, `period_meas` takes the number of clock cycles since the previous rising edge. It is updated in the same cycle that `sw_out` rises and holds otherwise.
- R5: The first rising edge after reset ends an unfinished period: `period_meas` stays 0 and `band_out` stays at `band_init`.
- R6: The period counter saturates, so a period longer than 2^PER_W − 1 cycles is reported as 2^PER_W − 1.
- R7: A finished period starts an update to floor(B × T / M). B is the band, T is `target_cycles` and M is the reported period, all three taken at the rising edge. The band updates within BAND_W+PER_W+4 cycles of that edge.
- R8: The updated band is clamped to the range from `band_min` to `band_max`, inclusive.
- R9: A rising edge that arrives while an update is still running starts no new update. The pending result is still applied. `period_meas` is still updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_in | input | ERR_W | Signed current error of this phase |
| shared_in | input | ERR_W | Signed error component common to all three phases |
| target_cycles | input | PER_W | Desired switching period in clock cycles |
| band_init | input | BAND_W | Band loaded at reset |
| band_min | input | BAND_W | Lower clamp for an updated band |
| band_max | input | BAND_W | Upper clamp for an updated band |
| sw_out | output | 1 | Switch state |
| period_meas | output | PER_W | Last measured switching period in cycles |
| band_out | output | BAND_W | Band currently used by the comparator |

## Verification
A corrupted band register shows up on `band_out` at once, and in the switching thresholds from the next sample. A wrong quotient or clamp bit becomes visible about BAND_W+PER_W+4 cycles after the rising edge that started the update. A wrong period counter appears on `period_meas` at the next rising edge, and it shifts the band of the following update. A lost busy interlock shows only when two rising edges come closer together than the update latency. The bench therefore places such pairs on purpose and checks that the band is not disturbed.

// File: rtl/ahc_pkg.sv
package ahc_pkg;

    // Band update sequencer states
    typedef enum logic [1:0] {
        UPD_IDLE,
        UPD_MUL,
        UPD_DIV,
        UPD_APPLY
    } upd_state_e;

    // Threshold crossing flags of the comparator
    typedef struct packed {
        logic above;
        logic below;
    } cross_t;

    // Counter width covering four nominal periods
    function automatic int period_bits(input int clk_hz, input int sw_hz);
        return $clog2(4 * (clk_hz / sw_hz));
    endfunction

endpackage

// File: rtl/ahc_comparator.sv
module ahc_comparator
    import ahc_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int BAND_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic signed [ERR_W-1:0]  shared_in,
    input  logic        [BAND_W-1:0] band,
    output logic                     sw,
    output logic                     rise
);
    localparam int MW = (ERR_W > BAND_W) ? ERR_W : BAND_W;
    localparam int NW = MW + 2;

    logic signed [NW-1:0] err_x, shr_x, nonint, band_p, band_n;
    cross_t               xing;
    logic                 sw_q, sw_d;

    always_comb begin
        err_x  = {{(NW-ERR_W){err_in[ERR_W-1]}}, err_in};
        shr_x  = {{(NW-ERR_W){shared_in[ERR_W-1]}}, shared_in};
        nonint = err_x - shr_x;
        band_p = {{(NW-BAND_W){1'b0}}, band};
        band_n = -band_p;
        xing.above = (nonint > band_p);
        xing.below = (nonint < band_n);
        if (xing.above)      sw_d = 1'b1;
        else if (xing.below) sw_d = 1'b0;
        else                 sw_d = sw_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= 1'b0;
        else     sw_q <= sw_d;
    end

    assign sw   = sw_q;
    assign rise = sw_d & ~sw_q & ~rst;
endmodule

// File: rtl/ahc_period_meter.sv
module ahc_period_meter #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    output logic             start,
    output logic [PER_W-1:0] sample,
    output logic [PER_W-1:0] meas
);
    localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};

    logic [PER_W-1:0] cnt_q, meas_q;
    logic             seen_q;

    // Value captured at a rising edge, saturating
    assign sample = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    assign start  = rise & seen_q;
    assign meas   = meas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            meas_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (rise) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
                if (seen_q) meas_q <= sample;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ahc_seq_divider.sv
module ahc_seq_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             running
);
    localparam int CW = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CW-1:0]    cnt_q;
    logic             run_q;
    logic [DEN_W:0]   rem_sh, diff;
    logic             fits;

    always_comb begin
        rem_sh = {rem_q, quo_q[NUM_W-1]};
        diff   = rem_sh - {1'b0, den};
        fits   = (rem_sh >= {1'b0, den});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            quo_q <= num;
            cnt_q <= CW'(NUM_W);
            run_q <= 1'b1;
        end else if (run_q) begin
            rem_q <= fits ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            quo_q <= {quo_q[NUM_W-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) run_q <= 1'b0;
        end
    end

    assign quo     = quo_q;
    assign running = run_q;
endmodule

// File: rtl/ahc_band_updater.sv
module ahc_band_updater
    import ahc_pkg::*;
#(
    parameter int BAND_W = 16,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PER_W-1:0]  sample,
    input  logic [PER_W-1:0]  target,
    input  logic [BAND_W-1:0] band_init,
    input  logic [BAND_W-1:0] band_min,
    input  logic [BAND_W-1:0] band_max,
    output logic [BAND_W-1:0] band
);
    localparam int PROD_W = BAND_W + PER_W;

    upd_state_e        state_q;
    logic [BAND_W-1:0] band_q, b_q;
    logic [PER_W-1:0]  t_q, m_q;
    logic [PROD_W-1:0] prod, quo, lo_x, hi_x;
    logic [BAND_W-1:0] clamped;
    logic              div_run;

    assign prod = PROD_W'(b_q) * PROD_W'(t_q);

    ahc_seq_divider #(
        .NUM_W(PROD_W),
        .DEN_W(PER_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .start  (state_q == UPD_MUL),
        .num    (prod),
        .den    (m_q),
        .quo    (quo),
        .running(div_run)
    );

    always_comb begin
        lo_x = PROD_W'(band_min);
        hi_x = PROD_W'(band_max);
        if (quo > hi_x)      clamped = band_max;
        else if (quo < lo_x) clamped = band_min;
        else                 clamped = quo[BAND_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UPD_IDLE;
            band_q  <= band_init;
            b_q     <= '0;
            t_q     <= '0;
            m_q     <= '0;
        end else begin
            unique case (state_q)
                UPD_IDLE: begin
                    // zero period keeps the band unchanged
                    if (start && sample != '0) begin
                        b_q     <= band_q;
                        t_q     <= target;
                        m_q     <= sample;
                        state_q <= UPD_MUL;
                    end
                end
                UPD_MUL:   state_q <= UPD_DIV;
                UPD_DIV:   if (!div_run) state_q <= UPD_APPLY;
                UPD_APPLY: begin
                    band_q  <= clamped;
                    state_q <= UPD_IDLE;
                end
                default:   state_q <= UPD_IDLE;
            endcase
        end
    end

    assign band = band_q;
endmodule

// File: rtl/adaptive_hyst_cmp.sv
module adaptive_hyst_cmp
    import ahc_pkg::*;
#(
    parameter int ERR_W  = 16,
    parameter int BAND_W = 16,
    parameter int CLK_HZ = 50_000_000,
    parameter int SW_HZ  = 5_000,
    parameter int PER_W  = period_bits(CLK_HZ, SW_HZ)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic signed [ERR_W-1:0]  shared_in,
    input  logic        [PER_W-1:0]  target_cycles,
    input  logic        [BAND_W-1:0] band_init,
    input  logic        [BAND_W-1:0] band_min,
    input  logic        [BAND_W-1:0] band_max,
    output logic                     sw_out,
    output logic        [PER_W-1:0]  period_meas,
    output logic        [BAND_W-1:0] band_out
);
    logic              rise, start;
    logic [PER_W-1:0]  sample;
    logic [BAND_W-1:0] band;

    ahc_comparator #(
        .ERR_W (ERR_W),
        .BAND_W(BAND_W)
    ) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .err_in   (err_in),
        .shared_in(shared_in),
        .band     (band),
        .sw       (sw_out),
        .rise     (rise)
    );

    ahc_period_meter #(
        .PER_W(PER_W)
    ) u_meter (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .start (start),
        .sample(sample),
        .meas  (period_meas)
    );

    ahc_band_updater #(
        .BAND_W(BAND_W),
        .PER_W (PER_W)
    ) u_upd (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sample   (sample),
        .target   (target_cycles),
        .band_init(band_init),
        .band_min (band_min),
        .band_max (band_max),
        .band     (band)
    );

    assign band_out = band;
endmodule

// File: rtl/ahc_checker.sv
module ahc_checker #(
    parameter int ERR_W  = 16,
    parameter int BAND_W = 16,
    parameter int PER_W  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic signed [ERR_W-1:0]  err_in,
    input logic signed [ERR_W-1:0]  shared_in,
    input logic        [BAND_W-1:0] band_min,
    input logic        [BAND_W-1:0] band_max,
    input logic                     sw_out,
    input logic        [PER_W-1:0]  period_meas,
    input logic        [BAND_W-1:0] band_out
);
    int diff_i, band_i;
    always_comb begin
        diff_i = int'(err_in) - int'(shared_in);
        band_i = int'({1'b0, band_out});
    end

    // R2
    rise_above_band_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sw_out) |-> $past(diff_i > band_i));

    // R2
    fall_below_band_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_out) |-> $past(diff_i < -band_i));

    // R4
    meas_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_meas) |-> $rose(sw_out));

    // R4
    meas_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(period_meas) |-> (period_meas != '0));

    // R8
    band_window_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(band_out) |-> (band_out >= band_min && band_out <= band_max));
endmodule

bind adaptive_hyst_cmp ahc_checker #(
    .ERR_W (ERR_W),
    .BAND_W(BAND_W),
    .PER_W (PER_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .err_in     (err_in),
    .shared_in  (shared_in),
    .band_min   (band_min),
    .band_max   (band_max),
    .sw_out     (sw_out),
    .period_meas(period_meas),
    .band_out   (band_out)
);

// File: tb/sim_adaptive_hyst_cmp.sv
module sim_adaptive_hyst_cmp;
    localparam int EW = 12, BW = 10, PW = 8;
    localparam int PMAX = 255;
    localparam int GAP = BW + PW + 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [EW-1:0] err = '0, shr = '0;
    logic [PW-1:0]        tgt = 8'd100;
    logic [BW-1:0]        binit = 10'd200, bmin = 10'd20, bmax = 10'd1000;
    logic                 sw;
    logic [PW-1:0]        meas;
    logic [BW-1:0]        band;

    int tests = 0, fails = 0;
    bit finished = 0;

    // model state
    int band_m, meas_m, last_acc, tcur, prev_n;
    bit seen_m;
    string band_tag, meas_tag;

    always #10 clk = ~clk;

    adaptive_hyst_cmp #(.ERR_W(EW), .BAND_W(BW), .PER_W(PW)) u0 (
        .clk(clk), .rst(rst), .err_in(err), .shared_in(shr),
        .target_cycles(tgt), .band_init(binit), .band_min(bmin),
        .band_max(bmax), .sw_out(sw), .period_meas(meas), .band_out(band));

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; err = '0; shr = '0;
        repeat (3) @(negedge clk);
        // R1: values during reset
        chk("R1 sw", int'(sw), 0);
        chk("R1 meas", int'(meas), 0);
        chk("R1 band", int'(band), int'(binit));
        rst = 1'b0;
        @(negedge clk);
        chk("R1 band after release", int'(band), int'(binit));
        band_m = int'(binit); meas_m = 0; last_acc = -1; tcur = 0;
        prev_n = 0; seen_m = 0;
    endtask

    function automatic int clampf(input int q);
        if (q > int'(bmax)) return int'(bmax);
        if (q < int'(bmin)) return int'(bmin);
        return q;
    endfunction

    // one rising edge now, next one n cycles later
    task automatic step(input int n);
        int q;
        band_tag = "R7";
        meas_tag = "R4";
        if (!seen_m) begin
            seen_m = 1;
            band_tag = "R5";
            meas_tag = "R5";
        end else begin
            meas_m = (prev_n > PMAX) ? PMAX : prev_n;
            if (prev_n > PMAX) meas_tag = "R6";
            if (last_acc < 0 || tcur - last_acc >= GAP) begin
                q = band_m * int'(tgt) / meas_m;
                if (clampf(q) != q) band_tag = "R8";
                band_m = clampf(q);
                last_acc = tcur;
            end else begin
                band_tag = "R9";
            end
        end
        prev_n = n;
        tcur += n;
        err = 12'sd2000;
        @(negedge clk) err = -12'sd2000;
        @(negedge clk) err = '0;
        repeat (n - 2) @(negedge clk);
        if (n >= 30) begin
            chk({meas_tag, " period_meas"}, int'(meas), meas_m);
            chk({band_tag, " band"}, int'(band), band_m);
        end
    endtask

    // comparator sweep with a fixed band
    task automatic sweep_point(input int v, inout int sw_m);
        int s;
        s = ((v * 37) % 61) - 30;
        err = EW'(v + s);
        shr = EW'(s);
        if (v > 100)       sw_m = 1;
        else if (v < -100) sw_m = 0;
        @(negedge clk);
        chk((s == 0) ? "R2 threshold" : "R3 shared offset", int'(sw), sw_m);
    endtask

    initial begin
        int sw_m;
        int pts[8];
        // fixed band 100 through clamping
        binit = 10'd100; bmin = 10'd100; bmax = 10'd100; tgt = 8'd100;
        do_reset();
        sw_m = 0;
        for (int v = -115; v <= 115; v++) sweep_point(v, sw_m);
        for (int v = 115; v >= -115; v--) sweep_point(v, sw_m);
        pts = '{100, 101, 100, 0, -100, -101, -100, 101};
        foreach (pts[i]) begin
            err = EW'(pts[i]); shr = '0;
            if (pts[i] > 100)       sw_m = 1;
            else if (pts[i] < -100) sw_m = 0;
            @(negedge clk);
            chk("R2 exact band edge", int'(sw), sw_m);
        end
        err = '0;
        chk("R2 band fixed", int'(band), 100);

        // adaptive run
        binit = 10'd200; bmin = 10'd20; bmax = 10'd1000; tgt = 8'd100;
        do_reset();
        step(120); step(80); step(100); step(50); step(60);
        step(5); step(90); step(300); step(45); step(40);
        step(70); step(130); step(6); step(7); step(64);
        tgt = 8'd250;
        step(40); step(40); step(40);
        tgt = 8'd40;
        step(250); step(250); step(250); step(250); step(100);
        tgt = 8'd173;
        step(99); step(173); step(201); step(33);

        // reset in mid run
        binit = 10'd333;
        do_reset();
        step(50); step(77); step(60);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule